// File: doc/BRIEF.md
# Oversampled Rate Control with Deadband

This block turns a noisy stream of 10-bit control readings into a steady 16-bit rate word for a low-frequency oscillator. It adds up readings in windows of 256. At the close of each window it scales the total down by sixteen and lifts it by a fixed floor of 0x0080, so the rate can never fall below that minimum.

The result then passes through a hysteresis stage. The held rate is replaced only when the new candidate lies at least 0x0010 away from it, in either direction. Small wobbles in the readings therefore never reach the oscillator.

Readings arrive on a valid/ready stream. The block accepts a word on every clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and stays high at all other times, so the block never applies back-pressure. A producer may leave gaps by dropping `in_valid`, and `in_data` is ignored in those cycles. The rate output is a plain registered word.

Top module: `ctl_rate_smoother`

## Requirements
- R1: While `rst_n` is low, `rate_o` reads 0x0080 and `in_ready` reads 0.
- R2: After reset, `in_ready` stays at 1. A cycle with `in_valid` low counts nothing and leaves `rate_o` unchanged, whatever `in_data` holds.
- R3: A window is exactly 256 accepted readings. `rate_o` can change only on the edge that accepts the 256th reading of a window.
- R4: The candidate for a window is (sum of its 256 readings shifted right by 4) plus 0x0080, and is never below 0x0080.
- R5: If the absolute difference between the candidate and the held rate is below 0x0010, `rate_o` keeps its value.
- R6: If that difference is 0x0010 or more, above or below the held rate, `rate_o` takes the candidate.
- R7: The running sum restarts from zero at the end of every window, whether or not the rate was updated.
- R8: A new rate is visible on `rate_o` in the cycle that follows the edge accepting the 256th reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Reading on `in_data` is valid |
| in_ready | output | 1 | Block accepts a reading this cycle |
| in_data | input | 10 | Unsigned control reading |
| rate_o | output | 16 | Held oscillator rate word |

## Verification
The only timed result is `rate_o`. It is due one edge after the 256th reading of a window is accepted, and before that edge it must still hold the previous value. The bench drives each reading on a falling edge, lets the next rising edge take it, and compares `rate_o` at the falling edge that follows. That places the window-closing check exactly one register after the acceptance. Idle cycles and in-window readings are checked at the same point, for an unchanged rate.

// File: rtl/ctl_rate_pkg.sv
package ctl_rate_pkg;
  localparam int unsigned RD_W     = 10;
  localparam int unsigned ACC_W    = 24;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned SHIFT    = 4;
  localparam int unsigned OUT_W    = 16;
  localparam logic [15:0] FLOOR    = 16'h0080;
  localparam logic [15:0] DEADBAND = 16'h0010;

  typedef struct packed {
    logic             close;
    logic [ACC_W-1:0] total;
  } win_evt_t;
endpackage

// File: rtl/ctl_window_accum.sv
module ctl_window_accum
  import ctl_rate_pkg::*;
#(
  parameter int unsigned DW = RD_W,
  parameter int unsigned AW = ACC_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] sample,
  output logic          close,
  output logic [AW-1:0] total
);
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_nx;

  // running sum including the sample offered this cycle
  assign acc_nx = acc_q + AW'(sample);
  assign close  = take && (cnt_q == LAST);
  assign total  = acc_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) acc_q <= '0;
      else               acc_q <= acc_nx;
    end
  end
endmodule

// File: rtl/ctl_scale_offset.sv
module ctl_scale_offset
  import ctl_rate_pkg::*;
#(
  parameter int unsigned AW   = ACC_W,
  parameter int unsigned OW   = OUT_W,
  parameter int unsigned SH   = SHIFT,
  parameter logic [OW-1:0] OFS = FLOOR
) (
  input  logic [AW-1:0] total,
  output logic [OW-1:0] cand
);
  localparam int unsigned HI_W = (AW > OW) ? AW - OW : 1;

  logic [AW-1:0] scaled;
  logic          over_hi;
  logic [OW:0]   sum_w;

  assign scaled = total >> SH;

  generate
    if (AW > OW) begin : g_wide
      assign over_hi = |scaled[AW-1:AW-HI_W];
    end else begin : g_narrow
      assign over_hi = 1'b0;
    end
  endgenerate

  assign sum_w = {1'b0, scaled[OW-1:0]} + {1'b0, OFS};

  // saturate instead of wrapping so the floor always holds
  always_comb begin
    if (over_hi || sum_w[OW]) cand = {OW{1'b1}};
    else                      cand = sum_w[OW-1:0];
  end
endmodule

// File: rtl/ctl_deadband_reg.sv
module ctl_deadband_reg
  import ctl_rate_pkg::*;
#(
  parameter int unsigned   OW   = OUT_W,
  parameter logic [OW-1:0] INIT = FLOOR,
  parameter logic [OW-1:0] BAND = DEADBAND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval,
  input  logic [OW-1:0] cand,
  output logic [OW-1:0] held
);
  logic [OW:0]   diff;
  logic [OW-1:0] mag;
  logic          load;

  assign diff = {1'b0, cand} - {1'b0, held};
  assign mag  = diff[OW] ? OW'(-diff) : diff[OW-1:0];
  assign load = eval && (mag >= BAND);

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= INIT;
    else if (load) held <= cand;
  end
endmodule

// File: rtl/ctl_rate_smoother.sv
module ctl_rate_smoother
  import ctl_rate_pkg::*;
#(
  parameter int unsigned      DW   = RD_W,
  parameter int unsigned      AW   = ACC_W,
  parameter int unsigned      CW   = CNT_W,
  parameter int unsigned      SH   = SHIFT,
  parameter int unsigned      OW   = OUT_W,
  parameter logic [OW-1:0]    OFS  = FLOOR,
  parameter logic [OW-1:0]    BAND = DEADBAND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic [OW-1:0] rate_o
);
  logic     rdy_q;
  logic     take;
  win_evt_t evt;
  logic [OW-1:0] cand;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign take     = in_valid && rdy_q;

  ctl_window_accum #(.DW(DW), .AW(AW), .CW(CW)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .sample(in_data),
    .close(evt.close), .total(evt.total)
  );

  ctl_scale_offset #(.AW(AW), .OW(OW), .SH(SH), .OFS(OFS)) u_scl (
    .total(evt.total), .cand(cand)
  );

  ctl_deadband_reg #(.OW(OW), .INIT(OFS), .BAND(BAND)) u_db (
    .clk(clk), .rst_n(rst_n), .eval(evt.close), .cand(cand), .held(rate_o)
  );
endmodule

// File: rtl/ctl_rate_smoother_chk.sv
module ctl_rate_smoother_chk #(
  parameter int unsigned   DW   = 10,
  parameter int unsigned   CW   = 8,
  parameter int unsigned   OW   = 16,
  parameter logic [OW-1:0] OFS  = 16'h0080,
  parameter logic [OW-1:0] BAND = 16'h0010
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic [OW-1:0] rate_o
);
  logic [CW-1:0] seen_q;
  logic          closing;

  always_ff @(posedge clk) begin
    if (!rst_n)                    seen_q <= '0;
    else if (in_valid && in_ready) seen_q <= seen_q + 1'b1;
  end

  assign closing = in_valid && in_ready && (seen_q == {CW{1'b1}});

  function automatic logic [OW-1:0] absdiff(input logic [OW-1:0] a, input logic [OW-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  p_only_at_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !closing |=> $stable(rate_o));

  p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rate_o >= OFS);

  p_step_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_o) |-> absdiff(rate_o, $past(rate_o)) >= BAND);
endmodule

bind ctl_rate_smoother ctl_rate_smoother_chk #(
  .DW(DW), .CW(CW), .OW(OW), .OFS(OFS), .BAND(BAND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .rate_o(rate_o)
);

// File: tb/tb_ctl_rate_smoother.sv
`timescale 1ns/1ps
module tb_ctl_rate_smoother;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_data = '0;
  logic [15:0] rate_o;

  int unsigned n_run = 0;
  int unsigned n_bad = 0;
  int unsigned m_cnt = 0;
  int unsigned m_acc = 0;
  logic [15:0] m_rate = 16'h0080;

  always #2 clk = ~clk;

  ctl_rate_smoother dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rate_o(rate_o)
  );

  function automatic logic [15:0] f_cand(input int unsigned s);
    int unsigned v = (s >> 4) + 32'h80;
    return (v > 32'hFFFF) ? 16'hFFFF : v[15:0];
  endfunction

  function automatic logic [15:0] f_next(input logic [15:0] r, input logic [15:0] c);
    int d = int'(c) - int'(r);
    if (d < 0) d = -d;
    return (d >= 16) ? c : r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_data = 10'($urandom);
    m_acc += d;
    m_cnt++;
    if (m_cnt == 256) begin
      m_rate = f_next(m_rate, f_cand(m_acc));
      m_acc = 0; m_cnt = 0;
      chk("R8 rate after window close", rate_o, m_rate);
    end else begin
      chk("R3 rate mid-window", rate_o, m_rate);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; in_data = 10'($urandom);
      @(negedge clk);
      chk("R2 idle ignored", rate_o, m_rate);
      chk("R2 ready high", in_ready, 1'b1);
    end
  endtask

  task automatic win_const(input logic [9:0] v);
    for (int i = 0; i < 256; i++) send(v);
  endtask

  task automatic win_target(input logic [15:0] t);
    int unsigned s = (int'(t) - 128) << 4;
    int unsigned q = s / 256;
    for (int i = 0; i < 255; i++) send(10'(q));
    send(10'(s - 255 * q));
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    chk("R1 reset rate", rate_o, 16'h0080);
    chk("R1 reset ready", in_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready after reset", in_ready, 1'b1);

    win_const(10'd0);            // R5: candidate equals rate, hold
    chk("R5 zero window hold", rate_o, 16'h0080);
    win_const(10'd1023);         // R4/R6: max sum
    chk("R4 full-scale candidate", rate_o, 16'h4070);
    win_const(10'd0);            // R7: sum restarted, drops to floor
    chk("R7 cleared sum", rate_o, 16'h0080);
    win_target(16'h1000);
    chk("R6 load upward", rate_o, 16'h1000);
    win_target(16'h100F);
    chk("R5 +0x0F held", rate_o, 16'h1000);
    win_target(16'h1010);
    chk("R6 +0x10 loaded", rate_o, 16'h1010);
    win_target(16'h1001);
    chk("R5 -0x0F held", rate_o, 16'h1010);
    win_target(16'h1000);
    chk("R6 -0x10 loaded", rate_o, 16'h1000);

    for (int w = 0; w < 6; w++) begin
      for (int i = 0; i < 256; i++) begin
        if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        send(10'($urandom_range(0, 1023) >> (w % 4)));
      end
    end
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule